// File: doc/BRIEF.md
# SQE Heartbeat and Jabber Guard

This block sits on the transmit side of a 10 Mb/s twisted-pair PHY and watches the transmit-enable line coming from the MAC. Whenever a frame ends, it waits a short programmable delay and then raises the collision output for a programmable number of cycles. This heartbeat lets the MAC confirm that the collision path is alive.

The block also guards against a transmitter that is stuck on. If transmit enable is sampled high for longer than a programmable limit, the block closes the transmitter gate and holds collision high. The lock is released only after transmit enable has been sampled low for a second, much longer, programmable quiet time. In 100 Mb/s mode the block is passive: collision stays low and the gate stays open.

The controller is a five-state machine. The states are IDLE (waiting for a frame), SEND (frame in progress, counting its length), SQE_WAIT (frame over, counting the heartbeat delay), SQE_PULSE (heartbeat on collision) and LOCK (jabber lockout). The transitions are as follows:
- IDLE→SEND when transmit enable is sampled high.
- SEND→SQE_WAIT when it is sampled low.
- SEND→LOCK when the length limit is exceeded.
- SQE_WAIT→SQE_PULSE once the delay has elapsed.
- SQE_WAIT→SEND and SQE_PULSE→SEND when a new frame starts early.
- SQE_PULSE→IDLE once the pulse width has elapsed.
- LOCK→IDLE once the quiet time is exceeded.
- Any state→IDLE whenever 100 Mb/s mode is selected.

Top module: `sqe_jabber_guard`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `col` is 0 and `tx_gate` is 1.
- R2: When `tx_en` is first sampled low at clock edge f after a frame of at most JAB_LIMIT_CYC high samples, `col` is 1 after edges f+SQE_DELAY_CYC through f+SQE_DELAY_CYC+SQE_WIDTH_CYC-1 and 0 otherwise.
- R3: A frame with at most JAB_LIMIT_CYC consecutive high samples of `tx_en` never lowers `tx_gate` and never raises `col` while the frame lasts.
- R4: On the (JAB_LIMIT_CYC+1)th consecutive high sample of `tx_en`, the block enters lockout: from that edge on `col`=1 and `tx_gate`=0, and both hold while `tx_en` stays high.
- R5: No heartbeat pulse follows a burst that caused a lockout; after release, `col` stays 0.
- R6: Lockout ends on the (QUIET_CYC+1)th consecutive low sample of `tx_en`; after that edge `col`=0 and `tx_gate`=1.
- R7: A high sample of `tx_en` during lockout restarts the quiet count from zero.
- R8: While `speed_10`=0 (100 Mb/s), `col`=0 and `tx_gate`=1 at once, whatever `tx_en` does, and the machine returns to IDLE. When 10 Mb/s mode is selected again, no pulse or lockout carries over.
- R9: A high sample of `tx_en` during the heartbeat delay or the heartbeat pulse cancels that heartbeat. A new frame then starts counting from that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| speed_10 | input | 1 | 1 = 10 Mb/s operation (guard active), 0 = 100 Mb/s (passive) |
| col | output | 1 | Collision output: heartbeat pulse or jabber indication |
| tx_gate | output | 1 | 1 = transmitter allowed, 0 = transmitter blocked by lockout |

## Verification
Every frame length from one sample up to three past the jabber limit is tried, each followed by a long silence. This sweep separates a normal frame with a heartbeat at an exact offset from a lockout with no heartbeat and a release at an exact offset, right at the limit boundary. Dedicated patterns then cover three more cases. The first breaks the quiet period with a short burst, so that a restarted count can be told apart from one that keeps running. The second restarts a frame inside the heartbeat delay and inside the pulse, to tell cancellation apart from a late pulse. The third drives long bursts in 100 Mb/s mode and switches mode during a lockout, to show that no state carries over.

// File: rtl/sjg_pkg.sv
package sjg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SEND      = 3'd1,
        ST_SQE_WAIT  = 3'd2,
        ST_SQE_PULSE = 3'd3,
        ST_LOCK      = 3'd4
    } sjg_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sjg_counter.sv
module sjg_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sjg_ctrl.sv
module sjg_ctrl
    import sjg_pkg::*;
#(
    parameter int JAB_LIMIT_CYC = 500_000,
    parameter int QUIET_CYC     = 6_250_000,
    parameter int SQE_DELAY_CYC = 20,
    parameter int SQE_WIDTH_CYC = 25,
    parameter int CW            = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          speed_10,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output logic          col_raw,
    output logic          gate_raw
);

    localparam logic [CW-1:0] JAB_LAST   = CW'(JAB_LIMIT_CYC - 1);
    localparam logic [CW-1:0] QUIET_LAST = CW'(QUIET_CYC);
    localparam logic [CW-1:0] DLY_LAST   = CW'(SQE_DELAY_CYC - 1);
    localparam logic [CW-1:0] WID_LAST   = CW'(SQE_WIDTH_CYC - 1);

    sjg_state_e st, nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = st;
        if (!speed_10) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (tx_en) nxt = ST_SEND;
                end
                ST_SEND: begin
                    if (!tx_en)                nxt = ST_SQE_WAIT;
                    else if (cnt == JAB_LAST)  nxt = ST_LOCK;
                end
                ST_SQE_WAIT: begin
                    if (tx_en)                 nxt = ST_SEND;
                    else if (cnt == DLY_LAST)  nxt = ST_SQE_PULSE;
                end
                ST_SQE_PULSE: begin
                    if (tx_en)                 nxt = ST_SEND;
                    else if (cnt == WID_LAST)  nxt = ST_IDLE;
                end
                ST_LOCK: begin
                    if (!tx_en && cnt == QUIET_LAST) nxt = ST_IDLE;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // counter control: restart on every state change and on any high
    // sample during lockout; count in every non-idle state
    always_comb begin
        cnt_clr = (nxt != st) || (st == ST_LOCK && tx_en);
        cnt_inc = (st != ST_IDLE);
    end

    // outputs (Moore)
    always_comb begin
        col_raw  = 1'b0;
        gate_raw = 1'b1;
        unique case (st)
            ST_SQE_PULSE: col_raw = 1'b1;
            ST_LOCK: begin
                col_raw  = 1'b1;
                gate_raw = 1'b0;
            end
            default: begin
                col_raw  = 1'b0;
                gate_raw = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sqe_jabber_guard.sv
module sqe_jabber_guard
    import sjg_pkg::*;
#(
    parameter int JAB_LIMIT_CYC = 500_000,
    parameter int QUIET_CYC     = 6_250_000,
    parameter int SQE_DELAY_CYC = 20,
    parameter int SQE_WIDTH_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic speed_10,
    output logic col,
    output logic tx_gate
);

    localparam int CNT_MAX = max2(max2(JAB_LIMIT_CYC, QUIET_CYC),
                                  max2(SQE_DELAY_CYC, SQE_WIDTH_CYC));
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic [CW-1:0] cnt;
    logic          cnt_clr;
    logic          cnt_inc;
    logic          col_raw;
    logic          gate_raw;

    sjg_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    sjg_ctrl #(
        .JAB_LIMIT_CYC (JAB_LIMIT_CYC),
        .QUIET_CYC     (QUIET_CYC),
        .SQE_DELAY_CYC (SQE_DELAY_CYC),
        .SQE_WIDTH_CYC (SQE_WIDTH_CYC),
        .CW            (CW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .speed_10 (speed_10),
        .cnt      (cnt),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .col_raw  (col_raw),
        .gate_raw (gate_raw)
    );

    // 100 Mb/s mode masks the guard immediately
    assign col     = speed_10 & col_raw;
    assign tx_gate = ~speed_10 | gate_raw;

endmodule

// File: rtl/sjg_checker.sv
module sjg_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic speed_10,
    input logic col,
    input logic tx_gate
);

    // R4: a closed gate always comes with collision asserted
    p_lock_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_10 && !tx_gate) |-> col);

    // R4: lockout is entered only on a high sample of tx_en
    p_lock_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_10 && $past(speed_10) && $fell(tx_gate)) |-> $past(tx_en));

    // R6: release only on a low sample of tx_en
    p_release_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_10 && $past(speed_10) && $rose(tx_gate)) |-> $past(!tx_en));

    // R2: a heartbeat starts only on a low sample of tx_en
    p_sqe_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(col) && tx_gate) |-> $past(!tx_en));

    // R8: passive in 100 Mb/s mode
    p_passive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!speed_10 && $past(!speed_10)) |-> (!col && tx_gate));

endmodule

bind sqe_jabber_guard sjg_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .speed_10 (speed_10),
    .col      (col),
    .tx_gate  (tx_gate)
);

// File: tb/sim_sqe_jabber_guard.sv
module sim_sqe_jabber_guard;

    localparam int JAB   = 20;
    localparam int QUIET = 50;
    localparam int DLY   = 3;
    localparam int WID   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic speed_10 = 1'b1;
    logic col;
    logic tx_gate;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sqe_jabber_guard #(
        .JAB_LIMIT_CYC (JAB),
        .QUIET_CYC     (QUIET),
        .SQE_DELAY_CYC (DLY),
        .SQE_WIDTH_CYC (WID)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .speed_10 (speed_10),
        .col      (col),
        .tx_gate  (tx_gate)
    );

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // drive tx_en at a falling edge, return after the next falling edge
    task automatic step(input logic en);
        tx_en = en;
        @(negedge clk);
    endtask

    function automatic logic exp_col(input int n, input int j);
        if (n <= JAB) return (j >= n + DLY) && (j < n + DLY + WID);
        return (j >= JAB) && (j < n + QUIET);
    endfunction

    function automatic logic exp_gate(input int n, input int j);
        if (n <= JAB) return 1'b1;
        return !((j >= JAB) && (j < n + QUIET));
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "col in reset", col, 1'b0);
        chk("R1", "tx_gate in reset", tx_gate, 1'b1);
        rst_n = 1'b1;
        step(1'b0);
        chk("R1", "col after reset", col, 1'b0);
        chk("R1", "tx_gate after reset", tx_gate, 1'b1);
        repeat (3) step(1'b0);

        // sweep of frame lengths across the jabber limit (R2 R3 R4 R5 R6)
        for (int n = 1; n <= JAB + 3; n++) begin
            for (int j = 0; j < n + QUIET + 6; j++) begin
                string rq;
                step(j < n);
                if (n > JAB) rq = (j < n) ? "R4" : ((j < n + QUIET) ? "R6" : "R5");
                else         rq = (j < n) ? "R3" : "R2";
                chk(rq, $sformatf("col n=%0d j=%0d", n, j), col, exp_col(n, j));
                chk(rq, $sformatf("tx_gate n=%0d j=%0d", n, j), tx_gate, exp_gate(n, j));
            end
        end

        // R7: quiet time restarts on a high sample
        repeat (JAB + 5) step(1'b1);
        chk("R7", "locked before quiet", tx_gate, 1'b0);
        repeat (QUIET - 10) step(1'b0);
        chk("R7", "still locked mid quiet", tx_gate, 1'b0);
        repeat (2) step(1'b1);
        chk("R7", "locked on interruption", col, 1'b1);
        for (int m = 0; m < QUIET + 8; m++) begin
            step(1'b0);
            chk("R7", $sformatf("tx_gate restart m=%0d", m), tx_gate, m >= QUIET);
            chk("R7", $sformatf("col restart m=%0d", m), col, m < QUIET);
        end

        // R9: new frame during the heartbeat delay
        repeat (5) step(1'b1);
        repeat (DLY - 1) step(1'b0);
        for (int k = 0; k < 5; k++) begin
            step(1'b1);
            chk("R9", $sformatf("no col refire k=%0d", k), col, 1'b0);
        end
        for (int m = 0; m < DLY; m++) begin
            step(1'b0);
            chk("R9", $sformatf("delay after restart m=%0d", m), col, 1'b0);
        end
        chk("R9", "pulse not yet", col, 1'b0);
        step(1'b0);
        chk("R9", "pulse after restarted frame", col, 1'b1);
        // R9: new frame during the pulse cuts it; frame counts from that sample
        for (int k = 0; k < JAB; k++) begin
            step(1'b1);
            chk("R9", $sformatf("pulse cut k=%0d", k), col, 1'b0);
            chk("R9", $sformatf("gate open k=%0d", k), tx_gate, 1'b1);
        end
        step(1'b1);
        chk("R9", "lock at limit+1 of new frame", tx_gate, 1'b0);
        repeat (QUIET + 1) step(1'b0);
        chk("R9", "released", tx_gate, 1'b1);
        repeat (DLY + WID + 2) step(1'b0);

        // R8: passive in 100 Mb/s mode
        speed_10 = 1'b0;
        for (int k = 0; k < JAB + 10; k++) begin
            step(1'b1);
            chk("R8", $sformatf("col 100M k=%0d", k), col, 1'b0);
            chk("R8", $sformatf("gate 100M k=%0d", k), tx_gate, 1'b1);
        end
        for (int k = 0; k < DLY + WID + 3; k++) begin
            step(1'b0);
            chk("R8", $sformatf("no pulse 100M k=%0d", k), col, 1'b0);
        end
        speed_10 = 1'b1;
        repeat (JAB + 2) step(1'b1);
        chk("R8", "locked in 10M", tx_gate, 1'b0);
        speed_10 = 1'b0;
        #1;
        chk("R8", "col drops on mode change", col, 1'b0);
        chk("R8", "gate opens on mode change", tx_gate, 1'b1);
        repeat (3) step(1'b1);
        step(1'b0);
        speed_10 = 1'b1;
        for (int k = 0; k < DLY + WID + 3; k++) begin
            step(1'b0);
            chk("R8", $sformatf("no carry col k=%0d", k), col, 1'b0);
            chk("R8", $sformatf("no carry gate k=%0d", k), tx_gate, 1'b1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule